// File: doc/BRIEF.md
# Transmit DMA Work Unit Sequencer

This block is a memory-to-peripheral DMA channel. Work units arrive on a descriptor port with a valid/ready handshake. Each work unit gives a start address, a word count, a word size, a direction tag, a memory-space tag, a sync bit, an interrupt enable and a stop flag. The channel reads the words through a simple pipelined memory read port, in order, and queues them in a small FIFO. It hands them to the peripheral on a valid/ready output.

The sync bit of a unit sets how the channel moves on to the next unit. With sync clear, the channel reports completion as soon as the last memory read has returned. It may then accept the next unit and start reading it while earlier words are still in the FIFO. Because of this overlap, the next unit must have the same attributes. With sync set, the FIFO must drain fully to the peripheral first. Only then are completion reported and a new unit accepted, and that new unit may then have any attributes.

The channel drives run, done and error status bits and an interrupt level. Dropping the channel enable discards everything that is queued.

Top module: `txdma_chan`

## Requirements
- R1: After reset, with the channel enabled, run, done, error, interrupt, peripheral valid and memory request are all 0 and descriptor ready is 1.
- R2: Word size code 0 selects 8-bit words, code 1 selects 16-bit words, and codes 2 and 3 select 32-bit words. The read address advances by 1, 2 or 4 per word. The delivered word holds the low bits of the memory data, zero-extended, and per_size repeats the code of the unit.
- R3: Every word of an executed unit reaches the peripheral exactly once and in address order, carrying the memory data read at its address.
- R4: A memory read is requested only while the FIFO count plus the number of reads in flight is below DEPTH. With the peripheral stalled, a long unit therefore issues exactly DEPTH reads.
- R5: With sync 0 and flow continue, the next unit's memory reads may start while the FIFO still holds words of the current unit.
- R6: After a sync-0, flow-continue unit, a next descriptor that differs in word size, direction or memory space is consumed but not executed. It sets the sticky error bit, issues no read, and returns the channel to idle.
- R7: For a sync-0 unit, done (and the interrupt, if enabled) rises one cycle after its last memory read returns, even when words are still queued. Run stays 1 while the FIFO holds words.
- R8: For a sync-1 unit, no next descriptor is accepted and no next read is issued until the FIFO is empty. Done rises one cycle after the FIFO empties, and at that point run is 0.
- R9: After a sync-1 unit, the next descriptor may use any word size, direction or memory space with no error. Its reads drive mem_space and mem_size from its own fields.
- R10: Clearing ch_en empties the FIFO and discards reads still in flight. No discarded word is ever delivered, and the channel returns to idle without setting done.
- R11: Done is sticky. A done_clr pulse clears both done and error. irq equals done AND the interrupt enable of the most recently completed unit.
- R12: A flow-stop unit returns the channel to idle. Idle accepts a descriptor only when the FIFO is empty and no reads are in flight. A flow-continue unit leaves descriptor ready high, waiting for the next unit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ch_en | input | 1 | Channel enable; 0 flushes and idles the channel |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Descriptor taken when high together with desc_valid |
| desc_addr | input | AW | Start address of the unit |
| desc_count | input | CW | Number of words in the unit |
| desc_size | input | 2 | Word size code |
| desc_dir | input | 1 | Direction tag, compared on continuous transitions |
| desc_space | input | 1 | Memory space select |
| desc_sync | input | 1 | 1 = drain the FIFO before completing |
| desc_irq_en | input | 1 | Interrupt enable for this unit |
| desc_stop | input | 1 | 1 = return to idle after this unit |
| mem_req | output | 1 | Memory read request, one word |
| mem_addr | output | AW | Read address |
| mem_size | output | 2 | Word size code of the read |
| mem_space | output | 1 | Memory space of the read |
| mem_rvalid | input | 1 | Read data return, in request order |
| mem_rdata | input | 32 | Read data |
| per_valid | output | 1 | Word available to the peripheral |
| per_ready | input | 1 | Peripheral accepts the word |
| per_data | output | 32 | Word to the peripheral |
| per_size | output | 2 | Size code of the word |
| done_clr | input | 1 | Pulse clearing done and error |
| sts_run | output | 1 | Unit active or words still queued or in flight |
| sts_done | output | 1 | Sticky completion flag |
| sts_err | output | 1 | Sticky continuous-transition mismatch flag |
| irq | output | 1 | Completion interrupt level |

## Verification
A read request appears in the cycle after a unit is taken. Its word enters the FIFO two cycles later, through the bench's two-cycle memory, and is offered to the peripheral in the next cycle. Done follows the completion condition of the selected sync mode by exactly one cycle. Because latencies vary with the stall pattern, the checks do not count fixed cycles. They poll on falling edges until the interrupt level rises, then sample run, valid and the scoreboard depth in that same cycle. Per-cycle watch flags record whether a given unit's reads were issued while words were still queued.

// File: rtl/txdma_pkg.sv
// Shared types and helpers for the transmit DMA channel.
// Assumes size code 3 behaves as 32-bit.
package txdma_pkg;

    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_DRAIN = 2'd2,
        ST_NEXT  = 2'd3
    } seq_state_e;

    // Address increment for one word of the given size code.
    function automatic logic [2:0] size_step(input logic [1:0] sz);
        case (sz)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    // Keep only the bits that belong to a word of the given size code.
    function automatic logic [WORD_W-1:0] size_trim(input logic [1:0] sz,
                                                    input logic [WORD_W-1:0] d);
        case (sz)
            2'd0:    return d & 32'h0000_00FF;
            2'd1:    return d & 32'h0000_FFFF;
            default: return d;
        endcase
    endfunction

endpackage

// File: rtl/txdma_fifo.sv
// Synchronous FIFO between memory returns and the peripheral.
// Assumes the writer never pushes into a full FIFO, because the reader throttles requests.
// flush empties the FIFO in one cycle.
module txdma_fifo #(
    parameter  int DEPTH = 8,
    parameter  int W     = 34,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [W-1:0]     wdata,
    input  logic             pop,
    output logic [W-1:0]     rdata,
    output logic [CNT_W-1:0] cnt,
    output logic             empty
);

    logic [W-1:0]     store [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;

    function automatic logic [PTR_W-1:0] ptr_adv(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Write the incoming word into the slot at the write pointer.
    always_ff @(posedge clk) begin
        if (push && !flush) store[wr_ptr] <= wdata;
    end

    // Move the pointers and the occupancy count; flush resets all three.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push) wr_ptr <= ptr_adv(wr_ptr);
            if (pop)  rd_ptr <= ptr_adv(rd_ptr);
            case ({push, pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    assign rdata = store[rd_ptr];
    assign empty = (cnt == '0);

    AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |-> (cnt != CNT_W'(DEPTH)));  // R4
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty);  // R10

endmodule

// File: rtl/txdma_reader.sv
// Address and word-count generator for the active unit.
// Issues one read per cycle while FIFO slots, counting reads in flight, remain.
// Assumes memory returns arrive in request order.
// Returns are pushed only while the channel is active in the read phase.
module txdma_reader
    import txdma_pkg::*;
#(
    parameter  int AW    = 32,
    parameter  int CW    = 16,
    parameter  int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int SUM_W = CNT_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             load,
    input  logic [AW-1:0]    load_addr,
    input  logic [CW-1:0]    load_cnt,
    input  logic [1:0]       size,
    input  logic [CNT_W-1:0] fifo_cnt,
    input  logic             mem_rvalid,
    output logic             mem_req,
    output logic [AW-1:0]    mem_addr,
    output logic             push,
    output logic [CNT_W-1:0] inflight,
    output logic             fetched
);

    logic [AW-1:0]    addr_q;
    logic [CW-1:0]    left_q;
    logic [SUM_W-1:0] occupancy;

    assign occupancy = SUM_W'(fifo_cnt) + SUM_W'(inflight);
    assign mem_req   = active && (left_q != '0) && (occupancy < SUM_W'(DEPTH));
    assign push      = mem_rvalid && active;
    assign fetched   = (left_q == '0) && (inflight == '0);
    assign mem_addr  = addr_q;

    // Load a new unit, or step the address and count on each issued read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            left_q <= '0;
        end else if (load) begin
            addr_q <= load_addr;
            left_q <= load_cnt;
        end else if (mem_req) begin
            addr_q <= addr_q + AW'(size_step(size));
            left_q <= left_q - 1'b1;
        end
    end

    // Count reads issued but not yet returned, including ones to be discarded.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inflight <= '0;
        end else begin
            case ({mem_req, mem_rvalid})
                2'b10:   inflight <= inflight + 1'b1;
                2'b01:   inflight <= inflight - 1'b1;
                default: inflight <= inflight;
            endcase
        end
    end

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> (mem_addr == $past(mem_addr) + AW'(size_step($past(size)))));  // R2

endmodule

// File: rtl/txdma_ctrl.sv
// Work-unit sequencer plus status bits.
// Holds the attributes of the current unit.
// Decides when a unit completes, depending on its sync bit.
// Checks continuous transitions for attribute mismatches.
// Assumes the reader reports 'fetched' once every read has returned.
module txdma_ctrl
    import txdma_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ch_en,
    input  logic       desc_valid,
    input  logic [1:0] desc_size,
    input  logic       desc_dir,
    input  logic       desc_space,
    input  logic       desc_sync,
    input  logic       desc_irq_en,
    input  logic       desc_stop,
    input  logic       fetched,
    input  logic       fifo_empty,
    input  logic       inflight_zero,
    input  logic       done_clr,
    output logic       desc_ready,
    output logic       load,
    output logic       active,
    output logic       busy,
    output logic [1:0] cur_size,
    output logic       cur_space,
    output logic       cur_sync,
    output logic       sts_done,
    output logic       sts_err,
    output logic       irq
);

    seq_state_e state_q, state_d;
    logic       cur_dir, cur_irq_en, cur_stop;
    logic       irq_sel_q;
    logic       accept, mismatch, cmpl;

    assign desc_ready = ch_en && ((state_q == ST_IDLE && fifo_empty && inflight_zero)
                                  || state_q == ST_NEXT);
    assign accept   = desc_valid && desc_ready;
    assign mismatch = (state_q == ST_NEXT) && !cur_sync &&
                      ((desc_size != cur_size) || (desc_dir != cur_dir) ||
                       (desc_space != cur_space));
    assign load     = accept && !mismatch;
    assign cmpl     = ch_en && (((state_q == ST_READ) && fetched && !cur_sync) ||
                                ((state_q == ST_DRAIN) && fifo_empty));
    assign active   = ch_en && (state_q == ST_READ);
    assign busy     = (state_q == ST_READ) || (state_q == ST_DRAIN);
    assign irq      = sts_done && irq_sel_q;

    // Choose the next sequencer state; losing the enable always idles the channel.
    always_comb begin
        state_d = state_q;
        if (!ch_en) begin
            state_d = ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE:  if (load) state_d = ST_READ;
                ST_READ:  if (fetched)
                              state_d = cur_sync ? ST_DRAIN : (cur_stop ? ST_IDLE : ST_NEXT);
                ST_DRAIN: if (fifo_empty) state_d = cur_stop ? ST_IDLE : ST_NEXT;
                ST_NEXT:  if (accept) state_d = mismatch ? ST_IDLE : ST_READ;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // Register the state and capture the attributes of each accepted unit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            cur_size   <= 2'd0;
            cur_dir    <= 1'b0;
            cur_space  <= 1'b0;
            cur_sync   <= 1'b0;
            cur_irq_en <= 1'b0;
            cur_stop   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (load) begin
                cur_size   <= desc_size;
                cur_dir    <= desc_dir;
                cur_space  <= desc_space;
                cur_sync   <= desc_sync;
                cur_irq_en <= desc_irq_en;
                cur_stop   <= desc_stop;
            end
        end
    end

    // Sticky done and error flags; a completion in the same cycle beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts_done  <= 1'b0;
            sts_err   <= 1'b0;
            irq_sel_q <= 1'b0;
        end else begin
            if (cmpl) begin
                sts_done  <= 1'b1;
                irq_sel_q <= cur_irq_en;
            end else if (done_clr) begin
                sts_done <= 1'b0;
            end
            if (accept && mismatch) sts_err <= 1'b1;
            else if (done_clr)      sts_err <= 1'b0;
        end
    end

    AST_SYNC_NEXT_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_NEXT && cur_sync) |-> fifo_empty);  // R8
    AST_ERR_GOES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && mismatch) |=> (state_q == ST_IDLE && sts_err));  // R6
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_done && !done_clr) |=> sts_done);  // R11

endmodule

// File: rtl/txdma_chan.sv
// Transmit DMA channel top level.
// Wires the sequencer, the read generator and the output FIFO together.
// Each FIFO entry carries the trimmed data word and its size code.
// Assumes memory reads are always accepted and return in request order.
module txdma_chan
    import txdma_pkg::*;
#(
    parameter  int AW    = 32,
    parameter  int CW    = 16,
    parameter  int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int ENT_W = WORD_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ch_en,
    input  logic              desc_valid,
    output logic              desc_ready,
    input  logic [AW-1:0]     desc_addr,
    input  logic [CW-1:0]     desc_count,
    input  logic [1:0]        desc_size,
    input  logic              desc_dir,
    input  logic              desc_space,
    input  logic              desc_sync,
    input  logic              desc_irq_en,
    input  logic              desc_stop,
    output logic              mem_req,
    output logic [AW-1:0]     mem_addr,
    output logic [1:0]        mem_size,
    output logic              mem_space,
    input  logic              mem_rvalid,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              per_valid,
    input  logic              per_ready,
    output logic [WORD_W-1:0] per_data,
    output logic [1:0]        per_size,
    input  logic              done_clr,
    output logic              sts_run,
    output logic              sts_done,
    output logic              sts_err,
    output logic              irq
);

    logic             load, active, busy, fetched, push, fifo_empty, cur_sync;
    logic [1:0]       cur_size;
    logic             cur_space;
    logic [CNT_W-1:0] fifo_cnt, inflight;
    logic [ENT_W-1:0] fifo_rd;

    txdma_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .desc_valid(desc_valid),
        .desc_size(desc_size), .desc_dir(desc_dir), .desc_space(desc_space),
        .desc_sync(desc_sync), .desc_irq_en(desc_irq_en), .desc_stop(desc_stop),
        .fetched(fetched), .fifo_empty(fifo_empty), .inflight_zero(inflight == '0),
        .done_clr(done_clr), .desc_ready(desc_ready), .load(load), .active(active),
        .busy(busy), .cur_size(cur_size), .cur_space(cur_space), .cur_sync(cur_sync),
        .sts_done(sts_done), .sts_err(sts_err), .irq(irq)
    );

    txdma_reader #(.AW(AW), .CW(CW), .DEPTH(DEPTH)) u_reader (
        .clk(clk), .rst_n(rst_n), .active(active), .load(load),
        .load_addr(desc_addr), .load_cnt(desc_count), .size(cur_size),
        .fifo_cnt(fifo_cnt), .mem_rvalid(mem_rvalid), .mem_req(mem_req),
        .mem_addr(mem_addr), .push(push), .inflight(inflight), .fetched(fetched)
    );

    txdma_fifo #(.DEPTH(DEPTH), .W(ENT_W)) u_fifo (
        .clk(clk), .rst_n(rst_n), .flush(!ch_en), .push(push),
        .wdata({cur_size, size_trim(cur_size, mem_rdata)}),
        .pop(per_valid && per_ready), .rdata(fifo_rd), .cnt(fifo_cnt),
        .empty(fifo_empty)
    );

    assign per_valid = !fifo_empty;
    assign per_data  = fifo_rd[WORD_W-1:0];
    assign per_size  = fifo_rd[ENT_W-1:WORD_W];
    assign mem_size  = cur_size;
    assign mem_space = cur_space;
    assign sts_run   = busy || !fifo_empty || (inflight != '0);

    AST_SYNC_DONE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sts_done) && cur_sync) |-> !sts_run);  // R8

endmodule

// File: tb/txdma_chan_test.sv
`timescale 1ns/1ps
module txdma_chan_test;

    logic        clk = 1'b0;
    logic        rst_n, ch_en, desc_valid, desc_ready;
    logic [31:0] desc_addr;
    logic [15:0] desc_count;
    logic [1:0]  desc_size;
    logic        desc_dir, desc_space, desc_sync, desc_irq_en, desc_stop;
    logic        mem_req, mem_space, mem_rvalid;
    logic [31:0] mem_addr, mem_rdata;
    logic [1:0]  mem_size;
    logic        per_valid, per_ready;
    logic [31:0] per_data;
    logic [1:0]  per_size;
    logic        done_clr, sts_run, sts_done, sts_err, irq;

    int vectors = 0;
    int miscompares = 0;
    int rdy_mode = 0;
    int delivered = 0;
    int req_cnt = 0;
    logic [31:0] watch_addr = 32'hFFFF_FFFF;
    bit watch_hit = 0, watch_hit_busy = 0, seen_space = 0;
    logic [33:0] expq [$];

    always #4 clk = ~clk;

    txdma_chan uut (.*);

    function automatic logic [31:0] memfn(input logic [31:0] a);
        return (a * 32'h0100_0193) ^ 32'hC0DE_1234;
    endfunction

    function automatic logic [31:0] trim(input logic [1:0] s, input logic [31:0] d);
        if (s == 2'd0) return {24'd0, d[7:0]};
        if (s == 2'd1) return {16'd0, d[15:0]};
        return d;
    endfunction

    // two-cycle pipelined memory model
    logic p1_v, p2_v;
    logic [31:0] p1_a, p2_a;
    always @(posedge clk) begin
        if (!rst_n) begin
            p1_v <= 1'b0; p2_v <= 1'b0; p1_a <= '0; p2_a <= '0;
        end else begin
            p1_v <= mem_req; p1_a <= mem_addr; p2_v <= p1_v; p2_a <= p1_a;
        end
    end
    assign mem_rvalid = p2_v;
    assign mem_rdata  = memfn(p2_a);

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    // peripheral ready pattern
    initial begin
        per_ready = 1'b0;
        forever begin
            @(posedge clk); #1;
            case (rdy_mode)
                0:       per_ready = 1'b0;
                1:       per_ready = 1'b1;
                default: per_ready = ~per_ready;
            endcase
        end
    end

    // monitor: scoreboard pops and watch flags
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (per_valid && per_ready) begin
                    delivered++;
                    if (expq.size() == 0) chk("R3 unexpected word", {30'd0, per_size, per_data}, 64'hDEAD);
                    else chk("R3 word order/data", {30'd0, per_size, per_data}, {30'd0, expq.pop_front()});
                end
                if (mem_req) begin
                    req_cnt++;
                    if (mem_addr == watch_addr) begin
                        watch_hit = 1;
                        if (per_valid) watch_hit_busy = 1;
                        seen_space = mem_space;
                    end
                end
            end
        end
    end

    task automatic arm_watch(input logic [31:0] a);
        watch_addr = a; watch_hit = 0; watch_hit_busy = 0; seen_space = 0; req_cnt = 0;
    endtask

    task automatic send_desc(input logic [31:0] a, input int n, input logic [1:0] s,
                             input bit dir, input bit sp, input bit sy, input bit ie,
                             input bit st, input bit exec);
        if (exec) begin
            for (int i = 0; i < n; i++) begin
                logic [31:0] wa;
                wa = a + i * ((s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4);
                expq.push_back({s, trim(s, memfn(wa))});
            end
        end
        @(posedge clk); #1;
        desc_addr = a; desc_count = 16'(n); desc_size = s; desc_dir = dir;
        desc_space = sp; desc_sync = sy; desc_irq_en = ie; desc_stop = st;
        desc_valid = 1'b1;
        forever begin
            @(negedge clk);
            if (desc_ready) break;
        end
        @(posedge clk); #1;
        desc_valid = 1'b0;
    endtask

    task automatic wait_irq(input string tag, input int limit);
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (irq) return;
        end
        chk({tag, " irq timeout"}, 0, 1);
    endtask

    task automatic pulse_clr();
        @(posedge clk); #1 done_clr = 1'b1;
        @(posedge clk); #1 done_clr = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual hung expected finish");
        summary();
        $finish;
    end

    initial begin
        int d0;
        rst_n = 0; ch_en = 1; desc_valid = 0; done_clr = 0;
        desc_addr = 0; desc_count = 0; desc_size = 0; desc_dir = 0; desc_space = 0;
        desc_sync = 0; desc_irq_en = 0; desc_stop = 0;
        repeat (5) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 run", sts_run, 0);   chk("R1 done", sts_done, 0);
        chk("R1 err", sts_err, 0);   chk("R1 irq", irq, 0);
        chk("R1 per_valid", per_valid, 0); chk("R1 mem_req", mem_req, 0);
        chk("R1 desc_ready", desc_ready, 1);

        // synchronized stop unit with a toggling peripheral
        rdy_mode = 2;
        send_desc(32'h100, 6, 2'd2, 0, 0, 1, 1, 1, 1);
        wait_irq("R8", 300);
        chk("R8 run low at done", sts_run, 0);
        chk("R8 all words out before done", expq.size(), 0);
        chk("R11 done with irq", sts_done, 1);
        chk("R12 idle after stop", desc_ready, 1);
        pulse_clr();
        @(negedge clk);
        chk("R11 done cleared", sts_done, 0);
        chk("R11 irq cleared", irq, 0);

        // continuous chain, peripheral stalled
        rdy_mode = 0;
        arm_watch(32'h300);
        send_desc(32'h200, 3, 2'd1, 0, 0, 0, 0, 0, 1);
        send_desc(32'h300, 2, 2'd1, 0, 0, 0, 1, 1, 1);
        wait_irq("R7", 200);
        chk("R5 next reads overlap queued data", watch_hit_busy, 1);
        chk("R7 words still queued at irq", per_valid, 1);
        chk("R7 run high while queued", sts_run, 1);
        chk("R12 idle waits for empty fifo", desc_ready, 0);
        rdy_mode = 1;
        repeat (30) @(negedge clk);
        chk("R7 run low after drain", sts_run, 0);
        chk("R3 chain fully delivered", expq.size(), 0);
        pulse_clr();

        // mismatch after a continuous unit: size, then direction
        rdy_mode = 1;
        arm_watch(32'h500);
        send_desc(32'h400, 2, 2'd2, 0, 0, 0, 0, 0, 1);
        send_desc(32'h500, 2, 2'd0, 0, 0, 0, 0, 1, 0);
        repeat (15) @(negedge clk);
        chk("R6 err on size mismatch", sts_err, 1);
        chk("R6 no read of rejected unit", watch_hit, 0);
        chk("R6 back to idle", desc_ready, 1);
        chk("R3 first unit delivered", expq.size(), 0);
        pulse_clr();
        @(negedge clk);
        chk("R11 clear drops err", sts_err, 0);
        send_desc(32'h580, 1, 2'd1, 0, 0, 0, 0, 0, 1);
        send_desc(32'h5C0, 1, 2'd1, 1, 0, 0, 0, 1, 0);
        repeat (15) @(negedge clk);
        chk("R6 err on direction mismatch", sts_err, 1);
        pulse_clr();

        // synchronized continue, then a dissimilar unit
        rdy_mode = 0;
        arm_watch(32'h800);
        send_desc(32'h700, 4, 2'd2, 0, 0, 1, 0, 0, 1);
        fork
            send_desc(32'h800, 3, 2'd0, 1, 1, 1, 1, 1, 1);
        join_none
        repeat (20) @(negedge clk);
        chk("R8 no next read before drain", watch_hit, 0);
        chk("R8 data held", per_valid, 1);
        rdy_mode = 1;
        wait_irq("R9", 200);
        chk("R9 no error on dissimilar unit", sts_err, 0);
        chk("R9 dissimilar unit read", watch_hit, 1);
        chk("R9 space follows unit", seen_space, 1);
        chk("R8 next reads only on empty fifo", watch_hit_busy, 0);
        chk("R8 run low at done", sts_run, 0);
        chk("R3 dissimilar chain delivered", expq.size(), 0);
        pulse_clr();

        // throttle and disable
        rdy_mode = 0;
        arm_watch(32'hFFFF_0000);
        send_desc(32'h900, 12, 2'd2, 0, 0, 1, 1, 1, 1);
        repeat (40) @(negedge clk);
        chk("R4 reads capped at depth", req_cnt, 8);
        chk("R10 fifo holding data", per_valid, 1);
        @(posedge clk); #1 ch_en = 1'b0;
        repeat (3) @(posedge clk);
        #1 expq.delete();
        ch_en = 1'b1;
        @(negedge clk);
        chk("R10 fifo discarded", per_valid, 0);
        rdy_mode = 1;
        d0 = delivered;
        repeat (20) @(negedge clk);
        chk("R10 nothing delivered after disable", delivered, d0);
        chk("R10 done not set", sts_done, 0);
        chk("R10 run low", sts_run, 0);
        chk("R10 idle", desc_ready, 1);

        // size code 3 behaves as 32-bit
        send_desc(32'hA00, 2, 2'd3, 0, 0, 1, 1, 1, 1);
        wait_irq("R2", 100);
        chk("R2 code 3 words delivered", expq.size(), 0);
        pulse_clr();

        repeat (5) @(posedge clk);
        summary();
        $finish;
    end

endmodule